// File: doc/BRIEF.md
# Per-Request Checkpoint Rollback Tracker

This block holds a small, fully associative table of page records that sit beside translation entries. It makes every memory write undoable for the length of one network request. Each record names an active physical page and a backup physical page. It also holds one dirty bit and one pending-restore bit per memory line, a restore-outstanding flag, and the epoch in which the page was last written. An epoch counter marks the request now being served.

Each read or write access, given as a page tag and a line index, gets back the physical page to use. Where needed it also gets a line copy command. A save command copies a line from the active page to the backup page, and is issued on the first write to that line in an epoch. A restore command copies a line from the backup page to the active page. When a failure is signalled, the lines written in the current epoch are marked for restore, and nothing is copied at that moment. Each marked line is restored only when it is next touched. No page is ever copied in bulk. Records are installed through a fill port, which stands in for the translation refill path.

Top module: `ckpt_rollback_tracker`

## Requirements
- R1: During and after reset, every output is zero, the epoch is zero and no record is valid, so an access after reset misses.
- R2: A fill writes record `fill_idx` with the given tag, active page and backup page. It clears that record's dirty and pending bits and stamps the record with the current epoch. Later accesses with that tag hit the record, and an access to a tag that was overwritten misses.
- R3: An access whose tag matches no valid record gives a response with `rsp_miss`=1, `rsp_page`=0 and no copy command, and it changes no table state.
- R4: An access gets its response exactly one cycle later, for one cycle only. In every cycle without a response all outputs are zero. A hit on a line that is not pending restore returns the active page.
- R5: A write to a line that is neither dirty in the current epoch nor pending restore returns the active page. It issues a save command (`copy_restore`=0, `copy_src`=active page, `copy_dst`=backup page, `copy_line`=the line) and marks the line dirty. A repeated write to that line in the same epoch issues no copy.
- R6: `req_start` advances the epoch by one, modulo 2^TS_W. A write to a page last written in an older epoch first discards that page's old dirty bits, so the first write in the new epoch saves the line again.
- R7: `fail` ORs each valid record's current-epoch dirty bits into its pending-restore bits, clears all dirty bits and copies nothing.
- R8: A read of a pending line returns the backup page and issues a restore command (`copy_restore`=1, `copy_src`=backup page, `copy_dst`=active page). It clears the pending bit, so the next read of that line returns the active page with no copy. Pending bits survive across epochs.
- R9: A write to a pending line returns the active page and issues no copy. It clears the pending bit and marks the line dirty, so a later failure in the same epoch makes the line pending again.
- R10: A second failure keeps the pending bits that have not yet been consumed and adds the new dirty lines to them.
- R11: When `fail` and `req_start` occur in the same cycle, the failure acts on the epoch that is ending. An access presented in the same cycle as `fail`, `req_start` or `fill_valid` is dropped and gets no response.
- R12: Dirty bits left from an older epoch are not made pending by a failure in a later epoch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Strobe: handling of a new request begins |
| fail | input | 1 | Strobe: the current request has failed |
| acc_valid | input | 1 | Access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_tag | input | TAG_W | Page tag of the access |
| acc_line | input | log2(LINES) | Line index within the page |
| fill_valid | input | 1 | Install a record |
| fill_idx | input | log2(ENTRIES) | Record slot to install |
| fill_tag | input | TAG_W | Tag of the new record |
| fill_active | input | PA_W | Active physical page |
| fill_backup | input | PA_W | Backup physical page |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_miss | output | 1 | Access matched no record |
| rsp_page | output | PA_W | Physical page to use |
| copy_valid | output | 1 | Line copy command present |
| copy_restore | output | 1 | 0 = active to backup, 1 = backup to active |
| copy_src | output | PA_W | Source page of the copy |
| copy_dst | output | PA_W | Destination page of the copy |
| copy_line | output | log2(LINES) | Line to copy |

## Verification
The bench targets lines whose state changes across an epoch boundary: pending bits that must outlive `req_start`, and dirty bits that must expire. A design that kept stale dirty bits would skip the save on the first write of a new epoch. A design that let stale bits through would restore lines that a later failure never touched. It also checks both orders of consuming a pending line, read then write and write then read, and a second failure that must merge rather than replace. A replacing design would lose restores that are still outstanding. The lowest and highest line indices, the combined `fail` with `req_start`, and accesses dropped by a simultaneous event are each checked. These catch errors in bit indexing, in event ordering and in priority.

// File: rtl/ckpt_pkg.sv
package ckpt_pkg;
    typedef enum logic {
        CP_SAVE    = 1'b0,
        CP_RESTORE = 1'b1
    } copy_dir_e;
endpackage

// File: rtl/ckpt_tag_match.sv
module ckpt_tag_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]       vld,
    input  logic [ENTRIES*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]         look,
    output logic                     hit,
    output logic [IDX_W-1:0]         idx
);
    // lowest matching slot wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (vld[e] && tags[e*TAG_W +: TAG_W] == look) begin
                hit = 1'b1;
                idx = IDX_W'(e);
            end
        end
    end
endmodule

// File: rtl/ckpt_line_ctl.sv
module ckpt_line_ctl
    import ckpt_pkg::*;
#(
    parameter int LINES   = 64,
    parameter int TS_W    = 8,
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              is_write,
    input  logic [LINE_W-1:0] line,
    input  logic [LINES-1:0]  dirty,
    input  logic [LINES-1:0]  rb,
    input  logic              rv,
    input  logic [TS_W-1:0]   lts,
    input  logic [TS_W-1:0]   gts,
    output logic [LINES-1:0]  dirty_n,
    output logic [LINES-1:0]  rb_n,
    output logic              rv_n,
    output logic [TS_W-1:0]   lts_n,
    output logic              copy_en,
    output copy_dir_e         copy_dir,
    output logic              use_backup
);
    logic [LINES-1:0] bit_m;
    logic [LINES-1:0] eff_dirty;
    logic             pend;

    always_comb begin
        bit_m      = LINES'(1) << line;
        eff_dirty  = (lts == gts) ? dirty : '0;
        pend       = rv & rb[line];
        dirty_n    = dirty;
        rb_n       = rb;
        lts_n      = lts;
        copy_en    = 1'b0;
        copy_dir   = CP_SAVE;
        use_backup = 1'b0;
        if (!is_write) begin
            if (pend) begin
                rb_n       = rb & ~bit_m;
                copy_en    = 1'b1;
                copy_dir   = CP_RESTORE;
                use_backup = 1'b1;
            end
        end else begin
            dirty_n = eff_dirty | bit_m;
            lts_n   = gts;
            if (pend) begin
                rb_n = rb & ~bit_m;
            end else if (!eff_dirty[line]) begin
                copy_en = 1'b1;
            end
        end
        rv_n = |rb_n;
    end
endmodule

// File: rtl/ckpt_rollback_tracker.sv
module ckpt_rollback_tracker
    import ckpt_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LINES   = 64,
    parameter int TAG_W   = 20,
    parameter int PA_W    = 24,
    parameter int TS_W    = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              fail,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [TAG_W-1:0]  acc_tag,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [PA_W-1:0]   fill_active,
    input  logic [PA_W-1:0]   fill_backup,
    output logic              rsp_valid,
    output logic              rsp_miss,
    output logic [PA_W-1:0]   rsp_page,
    output logic              copy_valid,
    output logic              copy_restore,
    output logic [PA_W-1:0]   copy_src,
    output logic [PA_W-1:0]   copy_dst,
    output logic [LINE_W-1:0] copy_line
);
    typedef struct packed {
        logic             vld;
        logic [TAG_W-1:0] tag;
        logic [PA_W-1:0]  act;
        logic [PA_W-1:0]  bak;
        logic [LINES-1:0] dirty;
        logic [LINES-1:0] rb;
        logic             rv;
        logic [TS_W-1:0]  lts;
    } rec_t;

    typedef struct packed {
        rec_t [ENTRIES-1:0] tbl;
        logic [TS_W-1:0]    gts;
        logic               rsp_valid;
        logic               rsp_miss;
        logic [PA_W-1:0]    rsp_page;
        logic               copy_valid;
        logic               copy_restore;
        logic [PA_W-1:0]    copy_src;
        logic [PA_W-1:0]    copy_dst;
        logic [LINE_W-1:0]  copy_line;
    } state_t;

    state_t s_d, s_q;

    logic [ENTRIES-1:0]       vld_vec;
    logic [ENTRIES*TAG_W-1:0] tag_flat;
    logic                     hit;
    logic [IDX_W-1:0]         hit_idx;
    rec_t                     sel;
    logic [LINES-1:0]         dirty_n, rb_n;
    logic                     rv_n;
    logic [TS_W-1:0]          lts_n;
    logic                     copy_en;
    copy_dir_e                copy_dir;
    logic                     use_backup;
    logic [TS_W-1:0]          epoch_q;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_flat
        assign vld_vec[e]                  = s_q.tbl[e].vld;
        assign tag_flat[e*TAG_W +: TAG_W]  = s_q.tbl[e].tag;
    end

    ckpt_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_match (
        .vld(vld_vec), .tags(tag_flat), .look(acc_tag), .hit(hit), .idx(hit_idx)
    );

    assign sel = s_q.tbl[hit_idx];

    ckpt_line_ctl #(.LINES(LINES), .TS_W(TS_W)) i_line (
        .is_write(acc_write), .line(acc_line), .dirty(sel.dirty), .rb(sel.rb),
        .rv(sel.rv), .lts(sel.lts), .gts(s_q.gts), .dirty_n(dirty_n), .rb_n(rb_n),
        .rv_n(rv_n), .lts_n(lts_n), .copy_en(copy_en), .copy_dir(copy_dir),
        .use_backup(use_backup)
    );

    always_comb begin
        s_d              = s_q;
        s_d.rsp_valid    = 1'b0;
        s_d.rsp_miss     = 1'b0;
        s_d.rsp_page     = '0;
        s_d.copy_valid   = 1'b0;
        s_d.copy_restore = 1'b0;
        s_d.copy_src     = '0;
        s_d.copy_dst     = '0;
        s_d.copy_line    = '0;
        if (fail) begin
            // failure acts on the epoch still current in this cycle
            for (int e = 0; e < ENTRIES; e++) begin
                if (s_q.tbl[e].vld) begin
                    s_d.tbl[e].rb    = s_q.tbl[e].rb |
                        ((s_q.tbl[e].lts == s_q.gts) ? s_q.tbl[e].dirty : '0);
                    s_d.tbl[e].dirty = '0;
                    s_d.tbl[e].rv    = |s_d.tbl[e].rb;
                end
            end
        end
        if (req_start) begin
            s_d.gts = s_q.gts + 1'b1;
        end
        if (fill_valid) begin
            s_d.tbl[fill_idx].vld   = 1'b1;
            s_d.tbl[fill_idx].tag   = fill_tag;
            s_d.tbl[fill_idx].act   = fill_active;
            s_d.tbl[fill_idx].bak   = fill_backup;
            s_d.tbl[fill_idx].dirty = '0;
            s_d.tbl[fill_idx].rb    = '0;
            s_d.tbl[fill_idx].rv    = 1'b0;
            s_d.tbl[fill_idx].lts   = s_d.gts;
        end
        if (acc_valid && !fail && !req_start && !fill_valid) begin
            s_d.rsp_valid = 1'b1;
            if (!hit) begin
                s_d.rsp_miss = 1'b1;
            end else begin
                s_d.tbl[hit_idx].dirty = dirty_n;
                s_d.tbl[hit_idx].rb    = rb_n;
                s_d.tbl[hit_idx].rv    = rv_n;
                s_d.tbl[hit_idx].lts   = lts_n;
                s_d.rsp_page           = use_backup ? sel.bak : sel.act;
                if (copy_en) begin
                    s_d.copy_valid   = 1'b1;
                    s_d.copy_restore = (copy_dir == CP_RESTORE);
                    s_d.copy_src     = (copy_dir == CP_RESTORE) ? sel.bak : sel.act;
                    s_d.copy_dst     = (copy_dir == CP_RESTORE) ? sel.act : sel.bak;
                    s_d.copy_line    = acc_line;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign epoch_q      = s_q.gts;
    assign rsp_valid    = s_q.rsp_valid;
    assign rsp_miss     = s_q.rsp_miss;
    assign rsp_page     = s_q.rsp_page;
    assign copy_valid   = s_q.copy_valid;
    assign copy_restore = s_q.copy_restore;
    assign copy_src     = s_q.copy_src;
    assign copy_dst     = s_q.copy_dst;
    assign copy_line    = s_q.copy_line;
endmodule

// File: rtl/ckpt_rollback_checker.sv
module ckpt_rollback_checker #(
    parameter int PA_W = 24,
    parameter int TS_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_start,
    input logic            fail,
    input logic            acc_valid,
    input logic            fill_valid,
    input logic            rsp_valid,
    input logic            rsp_miss,
    input logic [PA_W-1:0] rsp_page,
    input logic            copy_valid,
    input logic [PA_W-1:0] copy_src,
    input logic [TS_W-1:0] epoch
);
    // R3: a miss never carries a copy command
    p_miss_no_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_valid && !copy_valid));

    // R4: a response only follows an accepted access
    p_rsp_follows_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_valid && !fail && !req_start && !fill_valid));

    // R8: the page handed out is the copy source whenever a copy is issued
    p_page_is_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> (rsp_page == copy_src));

    // R7: a failure cycle produces no copy
    p_fail_no_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !copy_valid);

    // R11: an access colliding with an event is dropped
    p_drop_collision_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (fail || req_start || fill_valid)) |=> !rsp_valid);

    // R6: epoch steps by one on a request start
    p_epoch_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |=> (epoch == TS_W'($past(epoch) + 1'b1)));

    // R6: epoch holds otherwise
    p_epoch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_start |=> $stable(epoch));
endmodule

bind ckpt_rollback_tracker ckpt_rollback_checker #(.PA_W(PA_W), .TS_W(TS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .fail(fail),
    .acc_valid(acc_valid), .fill_valid(fill_valid), .rsp_valid(rsp_valid),
    .rsp_miss(rsp_miss), .rsp_page(rsp_page), .copy_valid(copy_valid),
    .copy_src(copy_src), .epoch(epoch_q)
);

// File: tb/test_ckpt_rollback_tracker.sv
`timescale 1ns/1ps
module test_ckpt_rollback_tracker;
    localparam int NE = 8;
    localparam int NL = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0, fail = 1'b0, acc_valid = 1'b0, acc_write = 1'b0;
    logic [19:0] acc_tag = '0;
    logic [5:0]  acc_line = '0;
    logic        fill_valid = 1'b0;
    logic [2:0]  fill_idx = '0;
    logic [19:0] fill_tag = '0;
    logic [23:0] fill_active = '0, fill_backup = '0;
    logic        rsp_valid, rsp_miss, copy_valid, copy_restore;
    logic [23:0] rsp_page, copy_src, copy_dst;
    logic [5:0]  copy_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    bit        m_vld[NE];
    int        m_tag[NE], m_act[NE], m_bak[NE], m_lts[NE];
    bit [63:0] m_dirty[NE], m_rb[NE];
    int        m_gts;
    int        e_rv, e_miss, e_page, e_cv, e_cr, e_src, e_dst, e_line;

    always #2 clk = ~clk;

    ckpt_rollback_tracker i_ckpt_rollback_tracker (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .fail(fail),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_tag(acc_tag),
        .acc_line(acc_line), .fill_valid(fill_valid), .fill_idx(fill_idx),
        .fill_tag(fill_tag), .fill_active(fill_active), .fill_backup(fill_backup),
        .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_page(rsp_page),
        .copy_valid(copy_valid), .copy_restore(copy_restore), .copy_src(copy_src),
        .copy_dst(copy_dst), .copy_line(copy_line)
    );

    task automatic check(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic compare_all(input string rq);
        check(rq, "rsp_valid", int'(rsp_valid), e_rv);
        check(rq, "rsp_miss", int'(rsp_miss), e_miss);
        check(rq, "rsp_page", int'(rsp_page), e_page);
        check(rq, "copy_valid", int'(copy_valid), e_cv);
        check(rq, "copy_restore", int'(copy_restore), e_cr);
        check(rq, "copy_src", int'(copy_src), e_src);
        check(rq, "copy_dst", int'(copy_dst), e_dst);
        check(rq, "copy_line", int'(copy_line), e_line);
    endtask

    task automatic model(input bit st, input bit fl, input bit av, input bit aw,
                         input int tg, input int ln, input bit fv, input int fi,
                         input int ft, input int fa, input int fb);
        int h;
        bit pend;
        e_rv = 0; e_miss = 0; e_page = 0; e_cv = 0; e_cr = 0; e_src = 0; e_dst = 0; e_line = 0;
        if (fl) begin
            for (int e = 0; e < NE; e++) begin
                if (m_vld[e]) begin
                    if (m_lts[e] == m_gts) m_rb[e] = m_rb[e] | m_dirty[e];
                    m_dirty[e] = '0;
                end
            end
        end
        if (st) m_gts = (m_gts + 1) % 256;
        if (fv) begin
            m_vld[fi] = 1; m_tag[fi] = ft; m_act[fi] = fa; m_bak[fi] = fb;
            m_dirty[fi] = '0; m_rb[fi] = '0; m_lts[fi] = m_gts;
        end
        if (av && !fl && !st && !fv) begin
            e_rv = 1;
            h = -1;
            for (int e = 0; e < NE; e++) if (h < 0 && m_vld[e] && m_tag[e] == tg) h = e;
            if (h < 0) begin
                e_miss = 1;
            end else begin
                pend = m_rb[h][ln];
                if (!aw) begin
                    if (pend) begin
                        e_page = m_bak[h]; e_cv = 1; e_cr = 1;
                        e_src = m_bak[h]; e_dst = m_act[h]; e_line = ln;
                        m_rb[h][ln] = 1'b0;
                    end else begin
                        e_page = m_act[h];
                    end
                end else begin
                    e_page = m_act[h];
                    if (m_lts[h] != m_gts) m_dirty[h] = '0;
                    m_lts[h] = m_gts;
                    if (pend) begin
                        m_rb[h][ln] = 1'b0;
                    end else if (!m_dirty[h][ln]) begin
                        e_cv = 1; e_src = m_act[h]; e_dst = m_bak[h]; e_line = ln;
                    end
                    m_dirty[h][ln] = 1'b1;
                end
            end
        end
    endtask

    // one clock: drive at the falling edge, model at the rising edge, compare at the next fall
    task automatic cyc(input string rq, input bit st, input bit fl, input bit av,
                       input bit aw, input int tg, input int ln, input bit fv,
                       input int fi, input int ft, input int fa, input int fb);
        req_start = st; fail = fl; acc_valid = av; acc_write = aw;
        acc_tag = 20'(tg); acc_line = 6'(ln); fill_valid = fv; fill_idx = 3'(fi);
        fill_tag = 20'(ft); fill_active = 24'(fa); fill_backup = 24'(fb);
        @(posedge clk);
        model(st, fl, av, aw, tg, ln, fv, fi, ft, fa, fb);
        @(negedge clk);
        req_start = 0; fail = 0; acc_valid = 0; fill_valid = 0;
        compare_all(rq);
    endtask

    task automatic rd(input string rq, input int tg, input int ln);
        cyc(rq, 0, 0, 1, 0, tg, ln, 0, 0, 0, 0, 0);
    endtask
    task automatic wr(input string rq, input int tg, input int ln);
        cyc(rq, 0, 0, 1, 1, tg, ln, 0, 0, 0, 0, 0);
    endtask
    task automatic fill(input string rq, input int i, input int tg, input int a, input int b);
        cyc(rq, 0, 0, 0, 0, 0, 0, 1, i, tg, a, b);
    endtask
    task automatic start(input string rq);
        cyc(rq, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic failc(input string rq);
        cyc(rq, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        m_gts = 0;
        for (int e = 0; e < NE; e++) begin
            m_vld[e] = 0; m_tag[e] = 0; m_act[e] = 0; m_bak[e] = 0;
            m_lts[e] = 0; m_dirty[e] = '0; m_rb[e] = '0;
        end
        e_rv = 0; e_miss = 0; e_page = 0; e_cv = 0; e_cr = 0; e_src = 0; e_dst = 0; e_line = 0;
        repeat (3) @(negedge clk);
        compare_all("R1");                       // outputs zero in reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");
        rd("R1", 5, 0);                          // empty table
        rd("R1", 5, 0);
        fill("R2", 0, 'h11, 'h100, 'h200);
        fill("R2", 1, 'h22, 'h300, 'h400);
        cyc("R11", 0, 0, 1, 1, 'h11, 1, 1, 2, 'h55, 'h500, 'h600); // access dropped by fill
        rd("R2", 'h11, 1);
        rd("R4", 'h11, 3);
        rd("R4", 'h11, 3);
        wr("R3", 'h33, 4);                       // miss
        rd("R2", 'h55, 9);                       // record from the colliding fill
        start("R6");
        wr("R5", 'h11, 7);
        wr("R5", 'h11, 7);
        wr("R5", 'h11, 2);
        wr("R5", 'h22, 63);
        wr("R5", 'h22, 0);
        failc("R7");
        rd("R8", 'h11, 7);
        rd("R8", 'h11, 7);
        wr("R9", 'h11, 2);
        wr("R9", 'h11, 2);
        failc("R10");
        rd("R10", 'h22, 63);
        rd("R9", 'h11, 2);
        start("R6");
        rd("R8", 'h22, 0);                       // pending across epochs
        rd("R8", 'h22, 0);
        wr("R6", 'h11, 7);
        wr("R6", 'h11, 7);
        cyc("R11", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0); // fail with start
        rd("R11", 'h11, 7);
        cyc("R11", 1, 0, 1, 0, 'h11, 7, 0, 0, 0, 0, 0); // access dropped by start
        wr("R12", 'h22, 5);
        start("R12");
        failc("R12");
        rd("R12", 'h22, 5);
        wr("R12", 'h22, 5);
        cyc("R11", 0, 1, 1, 1, 'h22, 6, 0, 0, 0, 0, 0); // access dropped by fail
        rd("R7", 'h22, 5);
        fill("R2", 0, 'h44, 'h700, 'h800);
        rd("R2", 'h11, 7);
        wr("R2", 'h44, 7);
        rd("R4", 'h44, 7);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule